// File: doc/BRIEF.md
# SCL Timing Generator

This block turns a fast source clock into the SCL waveform and the bit-timing strobes an I2C master needs. The source clock first passes through a pre-divider of depth D. Two nested programmable counters follow. The inner one divides the pre-divided clock by a sample count S and emits a sample strobe. The outer one counts T of those strobes and then flips SCL. One half period of SCL therefore lasts D·S·T source clocks, and the bus frequency is the source frequency over 2·D·S·T.

Two timing sets are held. The normal set serves standard and fast speeds. A separate high-speed set holds its own sample and step counts, and a two-bit enable code arms it. A transaction engine runs the generator with `enable`. It pulses `mc_done` once the master code has gone out at fast rate. If the high-speed set is armed, that set takes over at the next SCL edge. All configuration changes are applied only at an SCL edge, so a half period is never cut short. Computing the best divider pair is left to software.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl` is 1 and `sample_stb`, `phase_tick` and `hs_active` are 0. The divider register resets to hold 4, which means D = 5, and the timing register resets to 0, which means S = 1 and T = 1. Enabling without any write therefore gives half periods of 5 cycles.
- R2: While `enable` is high, `scl` toggles once every D·S·T clock cycles. The first toggle comes D·S·T cycles after the first enabled clock edge.
- R3: `sample_stb` is a one-cycle pulse every D·S cycles, counted from the last SCL edge. Each half period contains exactly T such pulses, and the last one coincides with the `phase_tick` of that edge.
- R4: Configuration fields use these encodings. Select code 0 writes the divider register, with D−1 in data bits 2:0. Select code 1 writes the timing register, with S−1 in bits 10:8 and T−1 in bits 5:0, which allows S up to 8 and T up to 64. Select code 2 writes the high-speed register, with S−1 in bits 14:12, T−1 in bits 10:8 (T up to 8) and the arm code in bits 1:0.
- R5: A write that arrives inside a half period leaves the length of that half period unchanged. It applies from the next half period on.
- R6: A write sampled on the same clock edge that ends a half period applies to the half period that starts at that edge.
- R7: When the high-speed register holds 3 in bits 1:0, a `mc_done` pulse during a run switches timing to the high-speed set at the next SCL edge. `hs_active` rises together with that edge's `phase_tick` and stays high until the generator goes idle.
- R8: When the high-speed arm code is not 3, a `mc_done` pulse has no effect. Half periods keep normal timing and `hs_active` stays 0.
- R9: When `enable` is low, `scl` is held at 1, no strobes or ticks appear, all counters are cleared and `hs_active` drops. A new run starts with a full half period.
- R10: `phase_tick` is a one-cycle pulse in the first cycle that shows the new SCL level after each transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low holds it idle |
| mc_done | input | 1 | Pulse: master code finished, request high-speed timing |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Register select: 0 divider, 1 timing, 2 high-speed |
| wr_data | input | DATA_W | Configuration write data |
| scl | output | 1 | SCL level |
| sample_stb | output | 1 | SDA sample strobe |
| phase_tick | output | 1 | Pulse at each SCL transition |
| hs_active | output | 1 | High-speed timing set in use |

## Verification
The collision that matters is a configuration write, or a `mc_done` pulse, landing on the very clock edge where a half period ends and the active timing set is reloaded. The write must bypass into that reload instead of waiting a further half period. The bench counts cycles from the previous `phase_tick`, so it can place a timing write exactly on that edge. It then judges the outcome only by the length and strobe count of the following half period. A second coincidence, the last sample strobe sharing its cycle with the SCL edge, is judged by checking that the strobe count and strobe spacing agree in every half period.

// File: rtl/scl_tg_pkg.sv
`timescale 1ns/1ps
package scl_tg_pkg;

   typedef enum logic [1:0] {
      SEL_DIV    = 2'd0,
      SEL_TIMING = 2'd1,
      SEL_HS     = 2'd2
   } cfg_sel_e;

   // field positions inside the configuration write word
   localparam int TIM_SMP_LSB = 8;
   localparam int TIM_STP_LSB = 0;
   localparam int HS_SMP_LSB  = 12;
   localparam int HS_STP_LSB  = 8;
   localparam int HS_ARM_LSB  = 0;
   localparam logic [1:0] HS_ARM_CODE = 2'b11;

endpackage

// File: rtl/scl_tg_cfg.sv
`timescale 1ns/1ps
module scl_tg_cfg
   import scl_tg_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DIV_W    = 3,
   parameter int DEF_DIV  = 5,
   parameter int SMP_W    = 3,
   parameter int STP_W    = 6,
   parameter int HS_STP_W = 3,
   parameter bit HS_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              boundary,
   input  logic              mc_done,
   input  logic              wr_en,
   input  cfg_sel_e          wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DIV_W-1:0]  act_div_m1,
   output logic [SMP_W-1:0]  act_smp_m1,
   output logic [STP_W-1:0]  act_stp_m1,
   output logic              hs_active
);

   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DEF_DIV - 1);

   logic [DIV_W-1:0]    div_q, div_n;
   logic [SMP_W-1:0]    tsmp_q, tsmp_n;
   logic [STP_W-1:0]    tstp_q, tstp_n;
   logic                hs_on_n;
   logic [SMP_W-1:0]    hsmp_n;
   logic [HS_STP_W-1:0] hstp_n;
   logic                pend_n;
   logic                hs_act_n;
   logic                load;
   logic                cfg_unused;

   assign cfg_unused = ^wr_data;

   // next value of the normal registers (bypassed into the reload)
   always_comb begin
      div_n  = div_q;
      tsmp_n = tsmp_q;
      tstp_n = tstp_q;
      if (wr_en) begin
         case (wr_sel)
            SEL_DIV:    div_n = wr_data[DIV_W-1:0];
            SEL_TIMING: begin
               tsmp_n = wr_data[TIM_SMP_LSB +: SMP_W];
               tstp_n = wr_data[TIM_STP_LSB +: STP_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_RST;
         tsmp_q <= '0;
         tstp_q <= '0;
      end else begin
         div_q  <= div_n;
         tsmp_q <= tsmp_n;
         tstp_q <= tstp_n;
      end
   end

   generate
      if (HS_EN) begin : g_hs
         logic                hon_q;
         logic [SMP_W-1:0]    hsmp_q;
         logic [HS_STP_W-1:0] hstp_q;
         logic                pend_q;
         logic                hs_wr;

         assign hs_wr = wr_en && (wr_sel == SEL_HS);

         always_comb begin
            hs_on_n = hon_q;
            hsmp_n  = hsmp_q;
            hstp_n  = hstp_q;
            if (hs_wr) begin
               hs_on_n = (wr_data[HS_ARM_LSB +: 2] == HS_ARM_CODE);
               hsmp_n  = wr_data[HS_SMP_LSB +: SMP_W];
               hstp_n  = wr_data[HS_STP_LSB +: HS_STP_W];
            end
         end

         assign pend_n = enable && (pend_q || mc_done);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hon_q  <= 1'b0;
               hsmp_q <= '0;
               hstp_q <= '0;
               pend_q <= 1'b0;
            end else begin
               hon_q  <= hs_on_n;
               hsmp_q <= hsmp_n;
               hstp_q <= hstp_n;
               pend_q <= boundary ? 1'b0 : pend_n;
            end
         end
      end else begin : g_no_hs
         assign hs_on_n = 1'b0;
         assign hsmp_n  = '0;
         assign hstp_n  = '0;
         assign pend_n  = 1'b0;
      end
   endgenerate

   assign hs_act_n = enable && hs_on_n && (hs_active || pend_n);
   assign load     = !enable || boundary;

   // active set: reloaded only while idle or at an SCL edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div_m1 <= DIV_RST;
         act_smp_m1 <= '0;
         act_stp_m1 <= '0;
         hs_active  <= 1'b0;
      end else if (load) begin
         act_div_m1 <= div_n;
         hs_active  <= hs_act_n;
         if (hs_act_n) begin
            act_smp_m1 <= hsmp_n;
            act_stp_m1 <= STP_W'(hstp_n);
         end else begin
            act_smp_m1 <= tsmp_n;
            act_stp_m1 <= tstp_n;
         end
      end
   end

   assert_hs_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !hs_active);

endmodule

// File: rtl/scl_tg_prediv.sv
`timescale 1ns/1ps
module scl_tg_prediv #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [DIV_W-1:0] div_m1,
   output logic             pre_tick
);

   logic [DIV_W-1:0] pc;

   assign pre_tick = enable && (pc == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pc <= '0;
      else if (!enable || pre_tick) pc <= '0;
      else                          pc <= pc + 1'b1;
   end

   assert_pc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (pc <= div_m1));

endmodule

// File: rtl/scl_tg_halfper.sv
`timescale 1ns/1ps
module scl_tg_halfper #(
   parameter int SMP_W = 3,
   parameter int STP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             pre_tick,
   input  logic [SMP_W-1:0] smp_m1,
   input  logic [STP_W-1:0] stp_m1,
   output logic             boundary,
   output logic             scl_o,
   output logic             stb_o,
   output logic             tick_o
);

   logic [SMP_W-1:0] sc;
   logic [STP_W-1:0] tc;
   logic             smp_hit;

   assign smp_hit  = pre_tick && (sc == smp_m1);
   assign boundary = smp_hit && (tc == stp_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc     <= '0;
         tc     <= '0;
         scl_o  <= 1'b1;
         stb_o  <= 1'b0;
         tick_o <= 1'b0;
      end else if (!enable) begin
         sc     <= '0;
         tc     <= '0;
         scl_o  <= 1'b1;
         stb_o  <= 1'b0;
         tick_o <= 1'b0;
      end else begin
         if (pre_tick) sc <= smp_hit ? '0 : sc + 1'b1;
         if (smp_hit)  tc <= boundary ? '0 : tc + 1'b1;
         if (boundary) scl_o <= ~scl_o;
         stb_o  <= smp_hit;
         tick_o <= boundary;
      end
   end

   assert_sc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (sc <= smp_m1));
   assert_tc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (tc <= stp_m1));

endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
   import scl_tg_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DIV_W    = 3,
   parameter int DEF_DIV  = 5,
   parameter int SMP_W    = 3,
   parameter int STP_W    = 6,
   parameter int HS_STP_W = 3,
   parameter bit HS_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              mc_done,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              scl,
   output logic              sample_stb,
   output logic              phase_tick,
   output logic              hs_active
);

   localparam int DIV_MAX = 1 << DIV_W;

   generate
      if (DEF_DIV < 1 || DEF_DIV > DIV_MAX) begin : g_bad_div
         $error("DEF_DIV must lie in 1..2**DIV_W");
      end
      if (SMP_W < 1 || SMP_W > 3) begin : g_bad_smp
         $error("SMP_W must be 1..3 to fit its fields");
      end
      if (STP_W < 1 || STP_W > TIM_SMP_LSB) begin : g_bad_stp
         $error("STP_W must fit below the sample field");
      end
      if (HS_STP_W < 1 || HS_STP_W > 3 || HS_STP_W > STP_W) begin : g_bad_hstp
         $error("HS_STP_W must be 1..3 and not exceed STP_W");
      end
      if (DATA_W < HS_SMP_LSB + SMP_W || DATA_W < DIV_W) begin : g_bad_data
         $error("DATA_W too narrow for the field layout");
      end
   endgenerate

   logic [DIV_W-1:0] act_div_m1;
   logic [SMP_W-1:0] act_smp_m1;
   logic [STP_W-1:0] act_stp_m1;
   logic             pre_tick;
   logic             boundary;

   scl_tg_cfg #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV),
      .SMP_W(SMP_W), .STP_W(STP_W), .HS_STP_W(HS_STP_W), .HS_EN(HS_EN)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .enable(enable), .boundary(boundary),
      .mc_done(mc_done), .wr_en(wr_en), .wr_sel(cfg_sel_e'(wr_sel)),
      .wr_data(wr_data), .act_div_m1(act_div_m1), .act_smp_m1(act_smp_m1),
      .act_stp_m1(act_stp_m1), .hs_active(hs_active)
   );

   scl_tg_prediv #(.DIV_W(DIV_W)) u_prediv (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .div_m1(act_div_m1), .pre_tick(pre_tick)
   );

   scl_tg_halfper #(.SMP_W(SMP_W), .STP_W(STP_W)) u_halfper (
      .clk(clk), .rst_n(rst_n), .enable(enable), .pre_tick(pre_tick),
      .smp_m1(act_smp_m1), .stp_m1(act_stp_m1), .boundary(boundary),
      .scl_o(scl), .stb_o(sample_stb), .tick_o(phase_tick)
   );

   assert_tick_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      phase_tick |-> (scl != $past(scl)));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (scl && !sample_stb && !phase_tick));
   assert_hs_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_active) |-> phase_tick);
   assert_edge_has_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      phase_tick |-> sample_stb);

endmodule

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;

   typedef struct {
      int len;
      int nstb;
      int gap;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        mc = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        scl, sample_stb, phase_tick, hs_active;

   int   n_chk = 0;
   int   n_fail = 0;
   exp_t q[$];
   exp_t e;
   int   cnt = 0;
   int   nstb_seen = 0;
   int   idle_n = 0;
   bit   exp_scl = 1'b1;

   always #2.5 clk = ~clk;

   scl_timing_gen u_scl_timing_gen (
      .clk(clk), .rst_n(rst_n), .enable(en), .mc_done(mc),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .scl(scl), .sample_stb(sample_stb), .phase_tick(phase_tick),
      .hs_active(hs_active)
   );

   task automatic chk(string req, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic nedge(int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic wr(logic [1:0] s, logic [15:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      nedge(1);
      wr_en = 1'b0;
   endtask

   task automatic push(int len, int nstb, int gap);
      exp_t x;
      x.len = len; x.nstb = nstb; x.gap = gap;
      q.push_back(x);
   endtask

   task automatic wait_size(int s);
      while (q.size() > s) nedge(1);
   endtask

   task automatic stop_run();
      wait_size(0);
      en = 1'b0;
      nedge(4);
   endtask

   task automatic pulse_mc();
      mc = 1'b1;
      nedge(1);
      mc = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         cnt = 0; nstb_seen = 0; exp_scl = 1'b1; idle_n = 0;
      end else if (!en) begin
         cnt = 0; nstb_seen = 0; exp_scl = 1'b1;
         idle_n++;
         if (idle_n == 3) begin
            chk("R9 idle scl", int'(scl), 1);
            chk("R9 idle strobes", int'(sample_stb) + int'(phase_tick), 0);
            chk("R9 idle hs_active", int'(hs_active), 0);
         end
      end else begin
         idle_n = 0;
         cnt++;
         if (sample_stb) begin
            nstb_seen++;
            if (q.size() > 0) chk("R3 strobe spacing", cnt % q[0].gap, 0);
         end
         if (phase_tick) begin
            exp_scl = !exp_scl;
            if (q.size() == 0) begin
               chk("R2 unexpected edge", cnt, 0);
            end else begin
               e = q.pop_front();
               chk("R2 half period", cnt, e.len);
               chk("R3 strobes per half", nstb_seen, e.nstb);
            end
            chk("R10 scl level at tick", int'(scl), int'(exp_scl));
            cnt = 0;
            nstb_seen = 0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      nedge(3);
      rst_n = 1'b1;
      nedge(1);
      // R1 reset state
      chk("R1 scl", int'(scl), 1);
      chk("R1 sample_stb", int'(sample_stb), 0);
      chk("R1 phase_tick", int'(phase_tick), 0);
      chk("R1 hs_active", int'(hs_active), 0);

      // R1/R2: defaults give D=5, S=1, T=1
      push(5, 1, 5); push(5, 1, 5); push(5, 1, 5);
      en = 1'b1;
      stop_run();

      // R2/R3/R5/R6: D=2, S=3, T=2 then mid-half and boundary writes
      wr(2'd0, 16'h0001);
      wr(2'd1, 16'h0201);
      push(12, 2, 6); push(12, 2, 6);
      push(8, 4, 2);  push(8, 4, 2); push(8, 4, 2);
      push(4, 2, 2);  push(4, 2, 2);
      en = 1'b1;
      wait_size(6);
      nedge(3);
      wr(2'd1, 16'h0003);   // R5: mid-half write, S=1 T=4
      wait_size(3);
      nedge(7);
      wr(2'd1, 16'h0001);   // R6: sampled on the boundary edge, S=1 T=2
      stop_run();

      // R7: high-speed set D=2, S=1, T=2 after master code
      wr(2'd1, 16'h0102);   // normal: S=2 T=3 -> 12
      wr(2'd2, 16'h0103);
      push(12, 3, 4); push(12, 3, 4); push(4, 2, 2); push(4, 2, 2);
      en = 1'b1;
      wait_size(3);
      nedge(3);
      pulse_mc();
      chk("R7 hs_active before edge", int'(hs_active), 0);
      wait_size(0);
      chk("R7 hs_active after edge", int'(hs_active), 1);
      stop_run();
      chk("R9 hs_active cleared", int'(hs_active), 0);

      // R8: arm code cleared, master code ignored
      wr(2'd2, 16'h0000);
      push(12, 3, 4); push(12, 3, 4); push(12, 3, 4);
      en = 1'b1;
      wait_size(2);
      nedge(3);
      pulse_mc();
      wait_size(0);
      chk("R8 hs_active stays low", int'(hs_active), 0);
      stop_run();

      // R8: arm code 2 (not 3) also leaves timing normal
      wr(2'd2, 16'h0102);
      push(12, 3, 4); push(12, 3, 4);
      en = 1'b1;
      nedge(3);
      pulse_mc();
      wait_size(0);
      chk("R8 non-3 code ignored", int'(hs_active), 0);
      stop_run();

      // R4: step field at 64 with D=1, S=1
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h003F);
      push(64, 64, 1); push(64, 64, 1);
      en = 1'b1;
      stop_run();

      // R4: sample field at 8 and divider at 8
      wr(2'd0, 16'h0007);
      wr(2'd1, 16'h0700);
      push(64, 1, 64); push(64, 1, 64);
      en = 1'b1;
      stop_run();

      // R9: restart begins a full half period
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0002);
      push(3, 3, 1); push(3, 3, 1);
      en = 1'b1;
      nedge(2);
      en = 1'b0;
      q.delete();
      nedge(4);
      push(3, 3, 1); push(3, 3, 1);
      en = 1'b1;
      stop_run();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule